// File: doc/BRIEF.md
# Integer Execute Stage with Constant Chaining

This block is the execute stage of a small 32-bit RISC pipeline that has sixteen 32-bit registers. The registers form two banks of eight, a low bank (indices 0 to 7) and a high bank (indices 8 to 15). Index bit 3 selects the bank, so registers `k` and `k+8` form a pair. Each cycle in which `exec_en` is high, the stage takes an operation code, two operand values, an 8-bit immediate and the destination and source register indices. One clock edge later it presents the result, the write enable and the register index to the register file.

The stage covers register arithmetic and logic. It has a shift whose amount is a signed register value: a positive amount shifts left and a negative amount shifts right arithmetically. It has signed and unsigned less-than. It has an 8-bit load and a shift-by-8-and-add load, so that four operations can build any 32-bit constant. It also has add and shift with a 6-bit signed constant, and register move. The constant operations may only read their destination register or that register's pair. Operations that break this rule, and the reserved codes, produce no register write. Field decoding, the register file and memory access sit outside this block.

Top module: `exe_unit`

## Requirements
- R1: Results are registered. The outputs for an operation issued with `exec_en` high appear after exactly one rising edge. After an edge where `exec_en` was low, `wr_en` is 0 and `result` and `wr_idx` keep their values. Reset clears `result`, `wr_en` and `wr_idx` to 0.
- R2: The codes 0 (add), 1 (subtract, `opa - opb`), 2 (and), 3 (or) and 4 (xor) compute on `opa` and `opb` modulo 2^32.
- R3: Code 5 shifts `opa` by the signed value in `opb`. A positive amount shifts left. A negative amount shifts right arithmetically by its magnitude. A magnitude of 32 or more gives 0 for a left shift and 32 copies of `opa[31]` for a right shift.
- R4: Code 6 writes `imm` zero-extended to 32 bits.
- R5: Code 7 writes `(opa << 8) + imm`. One code-6 operation followed by three code-7 operations with the bytes 0x87, 0x65, 0x43, 0x21, each fed the previous result, leaves 0x87654321.
- R6: Code 8 writes 1 if `opa < opb` as signed numbers and 0 otherwise. Code 9 does the same compare as unsigned numbers.
- R7: Code 12 writes `opa` plus `imm[5:0]` sign-extended. Code 13 shifts `opa` by the signed amount `imm[5:0]`, with the same rules as R3.
- R8: Codes 7, 12 and 13 write only if `src_idx` equals `dst_idx` or equals `dst_idx` with bit 3 inverted. Otherwise `wr_en` stays 0.
- R9: Code 14 copies `opa` to the result unchanged.
- R10: Codes 10, 11 and 15 never assert `wr_en`.
- R11: `wr_idx` carries the `dst_idx` of the operation issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | An operation is issued this cycle |
| op | input | 4 | Operation code |
| dst_idx | input | 4 | Destination register index |
| src_idx | input | 4 | Source register index used for the pairing rule |
| opa | input | 32 | First operand, the source register value |
| opb | input | 32 | Second operand register value |
| imm | input | 8 | Immediate field |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Registered register-file write enable |
| wr_idx | output | 4 | Registered destination index |

## Verification
The shifts are tried with small positive and negative amounts, and with magnitudes at and beyond the word width and at the 6-bit limit of -32. These separate arithmetic from logical right shifts and show the saturation at large magnitudes. The compares use operands whose signed and unsigned orderings differ. The load sequence feeds each result back so that the byte order is checked end to end. The load with a high-bit-set byte tells zero extension apart from sign extension. Brother, same and unrelated source indices and the reserved codes check that the write enable is suppressed only where it should be.

// File: rtl/exe_pkg.sv
package exe_pkg;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 4;
  localparam int IMM_W   = 8;
  localparam int SIMM_W  = 6;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHV  = 4'd5,
    OP_LDB  = 4'd6,
    OP_SLB  = 4'd7,
    OP_LTS  = 4'd8,
    OP_LTU  = 4'd9,
    OP_RSA  = 4'd10,
    OP_RSB  = 4'd11,
    OP_ADC  = 4'd12,
    OP_SHC  = 4'd13,
    OP_MOV  = 4'd14,
    OP_RSC  = 4'd15
  } exe_op_e;
endpackage

// File: rtl/exe_shift.sv
module exe_shift #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic [DW-1:0] val,
  input  logic [AW-1:0] amt,
  output logic [DW-1:0] res
);
  localparam int MW = AW + 1;
  localparam int SW = $clog2(DW);

  logic          neg;
  logic [MW-1:0] amt_ext;
  logic [MW-1:0] mag;
  logic          big;
  logic [SW-1:0] sa;
  logic [DW-1:0] left;
  logic [DW-1:0] right;

  always_comb begin
    neg     = amt[AW-1];
    amt_ext = {amt[AW-1], amt};
    mag     = neg ? (MW'(0) - amt_ext) : amt_ext;
    big     = (64'(mag) >= 64'(DW));
    sa      = mag[SW-1:0];
    left    = val << sa;
    right   = DW'($signed(val) >>> sa);
    if (big) res = neg ? {DW{val[DW-1]}} : '0;
    else     res = neg ? right : left;
  end
endmodule

// File: rtl/exe_alu.sv
module exe_alu
  import exe_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  exe_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  logic [DW-1:0] shv;
  logic          lts;
  logic          ltu;

  exe_shift #(.DW(DW), .AW(DW)) u_shv (.val(a), .amt(b), .res(shv));

  always_comb begin
    lts = ($signed(a) < $signed(b));
    ltu = (a < b);
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SHV:  res = shv;
      OP_LTS:  res = DW'(lts);
      OP_LTU:  res = DW'(ltu);
      OP_MOV:  res = a;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/exe_imm.sv
module exe_imm
  import exe_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W,
  parameter int CW = SIMM_W
) (
  input  exe_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] res
);
  logic [CW-1:0] cst;
  logic [DW-1:0] cst_ext;
  logic [DW-1:0] shc;

  assign cst     = imm[CW-1:0];
  assign cst_ext = {{(DW-CW){cst[CW-1]}}, cst};

  exe_shift #(.DW(DW), .AW(CW)) u_shc (.val(a), .amt(cst), .res(shc));

  always_comb begin
    case (op)
      OP_LDB:  res = DW'(imm);
      OP_SLB:  res = (a << IW) + DW'(imm);
      OP_ADC:  res = a + cst_ext;
      OP_SHC:  res = shc;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/exe_unit.sv
module exe_unit
  import exe_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int XW = IDX_W,
  parameter int IW = IMM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [3:0]    op,
  input  logic [XW-1:0] dst_idx,
  input  logic [XW-1:0] src_idx,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] result,
  output logic          wr_en,
  output logic [XW-1:0] wr_idx
);
  exe_op_e       op_e;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] imm_res;
  logic          is_imm;
  logic          needs_pair;
  logic          pair_ok;
  logic          is_rsvd;
  logic [DW-1:0] res_d;
  logic          wen_d;
  logic [DW-1:0] res_q;
  logic          wen_q;
  logic [XW-1:0] idx_q;

  assign op_e = exe_op_e'(op);

  exe_alu #(.DW(DW)) u_alu (.op(op_e), .a(opa), .b(opb), .res(alu_res));
  exe_imm #(.DW(DW), .IW(IW)) u_imm (.op(op_e), .a(opa), .imm(imm), .res(imm_res));

  always_comb begin
    is_imm     = (op_e inside {OP_LDB, OP_SLB, OP_ADC, OP_SHC});
    needs_pair = (op_e inside {OP_SLB, OP_ADC, OP_SHC});
    is_rsvd    = (op_e inside {OP_RSA, OP_RSB, OP_RSC});
    pair_ok    = (src_idx == dst_idx) ||
                 (src_idx == {~dst_idx[XW-1], dst_idx[XW-2:0]});
    res_d      = is_imm ? imm_res : alu_res;
    wen_d      = exec_en && !is_rsvd && (!needs_pair || pair_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wen_q <= 1'b0;
      idx_q <= '0;
    end else begin
      wen_q <= wen_d;
      if (exec_en) begin
        res_q <= res_d;
        idx_q <= dst_idx;
      end
    end
  end

  assign result = res_q;
  assign wr_en  = wen_q;
  assign wr_idx = idx_q;

  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> !wr_en);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(result));
  a_r6_cmp_bool: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op == 4'd8 || op == 4'd9)) |=> (result[DW-1:1] == '0));
  a_r8_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op == 4'd7 || op == 4'd12 || op == 4'd13) &&
     (src_idx[XW-2:0] != dst_idx[XW-2:0])) |=> !wr_en);
  a_r9_move: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op == 4'd14) |=> (result == $past(opa)));
  a_r10_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op == 4'd10 || op == 4'd11 || op == 4'd15)) |=> !wr_en);
  a_r11_index: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> (wr_idx == $past(dst_idx)));
endmodule

// File: tb/exe_unit_tb.sv
module exe_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        exec_en;
  logic [3:0]  op;
  logic [3:0]  dst_idx;
  logic [3:0]  src_idx;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [7:0]  imm;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  wr_idx;

  int n_chk  = 0;
  int n_fail = 0;

  exe_unit u_dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op),
    .dst_idx(dst_idx), .src_idx(src_idx), .opa(opa), .opb(opb), .imm(imm),
    .result(result), .wr_en(wr_en), .wr_idx(wr_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [3:0] d, input logic [3:0] s,
                       input logic [31:0] a, input logic [31:0] b, input logic [7:0] i);
    @(negedge clk);
    exec_en = 1'b1; op = o; dst_idx = d; src_idx = s; opa = a; opb = b; imm = i;
    @(posedge clk);
    #1;
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset result", result, 32'h0);
    chk("R1 reset wr_en", {31'h0, wr_en}, 32'h0);
    chk("R1 reset wr_idx", {28'h0, wr_idx}, 32'h0);
  endtask

  task automatic t_logic;
    issue(4'd0, 4'd3, 4'd3, 32'd5, 32'd7, 8'h0);
    chk("R2 add", result, 32'd12);
    chk("R2 add wr_en", {31'h0, wr_en}, 32'h1);
    chk("R11 wr_idx", {28'h0, wr_idx}, 32'd3);
    issue(4'd1, 4'd9, 4'd1, 32'd3, 32'd5, 8'h0);
    chk("R2 sub", result, 32'hFFFF_FFFE);
    chk("R11 wr_idx high bank", {28'h0, wr_idx}, 32'd9);
    issue(4'd2, 4'd1, 4'd1, 32'hF0F0_1234, 32'h0FF0_FF00, 8'h0);
    chk("R2 and", result, 32'h00F0_1200);
    issue(4'd3, 4'd1, 4'd1, 32'hF000_000F, 32'h0A00_0A00, 8'h0);
    chk("R2 or", result, 32'hFA00_0A0F);
    issue(4'd4, 4'd1, 4'd1, 32'hFFFF_0000, 32'h0F0F_0F0F, 8'h0);
    chk("R2 xor", result, 32'hF0F0_0F0F);
  endtask

  task automatic t_shift;
    issue(4'd5, 4'd2, 4'd2, 32'd1, 32'd4, 8'h0);
    chk("R3 left 4", result, 32'd16);
    issue(4'd5, 4'd2, 4'd2, 32'h8000_0000, 32'hFFFF_FFFC, 8'h0);
    chk("R3 arith right 4", result, 32'hF800_0000);
    issue(4'd5, 4'd2, 4'd2, 32'h0000_0040, 32'hFFFF_FFFF, 8'h0);
    chk("R3 right 1", result, 32'h0000_0020);
    issue(4'd5, 4'd2, 4'd2, 32'hFFFF_FFFF, 32'd32, 8'h0);
    chk("R3 left 32 zero", result, 32'h0);
    issue(4'd5, 4'd2, 4'd2, 32'h8000_0001, 32'hFFFF_FFD8, 8'h0);
    chk("R3 right 40 sign fill", result, 32'hFFFF_FFFF);
    issue(4'd5, 4'd2, 4'd2, 32'h7FFF_FFFF, 32'h8000_0000, 8'h0);
    chk("R3 most negative amount", result, 32'h0);
  endtask

  task automatic t_load;
    logic [31:0] acc;
    issue(4'd6, 4'd4, 4'd4, 32'hDEAD_BEEF, 32'h0, 8'hF0);
    chk("R4 zero extend", result, 32'h0000_00F0);
    issue(4'd6, 4'd4, 4'd4, 32'h0, 32'h0, 8'h87);
    acc = result;
    issue(4'd7, 4'd4, 4'd4, acc, 32'h0, 8'h65);
    acc = result;
    issue(4'd7, 4'd4, 4'd12, acc, 32'h0, 8'h43);
    acc = result;
    issue(4'd7, 4'd4, 4'd4, acc, 32'h0, 8'h21);
    chk("R5 chain", result, 32'h8765_4321);
    chk("R5 chain wr_en", {31'h0, wr_en}, 32'h1);
  endtask

  task automatic t_compare;
    issue(4'd8, 4'd5, 4'd5, 32'hFFFF_FFFF, 32'd1, 8'h0);
    chk("R6 signed lt", result, 32'd1);
    issue(4'd9, 4'd5, 4'd5, 32'hFFFF_FFFF, 32'd1, 8'h0);
    chk("R6 unsigned not lt", result, 32'd0);
    issue(4'd9, 4'd5, 4'd5, 32'd1, 32'hFFFF_FFFF, 8'h0);
    chk("R6 unsigned lt", result, 32'd1);
    issue(4'd8, 4'd5, 4'd5, 32'd7, 32'd7, 8'h0);
    chk("R6 equal", result, 32'd0);
  endtask

  task automatic t_const;
    issue(4'd12, 4'd6, 4'd14, 32'd10, 32'h0, 8'hFF);
    chk("R7 add -1 from brother", result, 32'd9);
    chk("R8 brother writes", {31'h0, wr_en}, 32'h1);
    issue(4'd12, 4'd6, 4'd6, 32'd10, 32'h0, 8'h1F);
    chk("R7 add 31", result, 32'd41);
    issue(4'd13, 4'd6, 4'd6, 32'h8000_0000, 32'h0, 8'h20);
    chk("R7 shift -32", result, 32'hFFFF_FFFF);
    issue(4'd13, 4'd6, 4'd6, 32'd1, 32'h0, 8'h1F);
    chk("R7 shift 31", result, 32'h8000_0000);
  endtask

  task automatic t_pair;
    issue(4'd12, 4'd1, 4'd2, 32'd10, 32'h0, 8'h01);
    chk("R8 unrelated source", {31'h0, wr_en}, 32'h0);
    issue(4'd7, 4'd9, 4'd3, 32'd10, 32'h0, 8'h01);
    chk("R8 shift-load bad source", {31'h0, wr_en}, 32'h0);
    issue(4'd13, 4'd11, 4'd3, 32'd1, 32'h0, 8'h01);
    chk("R8 high to low brother", {31'h0, wr_en}, 32'h1);
  endtask

  task automatic t_misc;
    issue(4'd14, 4'd7, 4'd0, 32'hCAFE_F00D, 32'h1234_5678, 8'hAA);
    chk("R9 move", result, 32'hCAFE_F00D);
    issue(4'd10, 4'd7, 4'd7, 32'd1, 32'd1, 8'h0);
    chk("R10 code 10", {31'h0, wr_en}, 32'h0);
    issue(4'd11, 4'd7, 4'd7, 32'd1, 32'd1, 8'h0);
    chk("R10 code 11", {31'h0, wr_en}, 32'h0);
    issue(4'd15, 4'd7, 4'd7, 32'd1, 32'd1, 8'h0);
    chk("R10 code 15", {31'h0, wr_en}, 32'h0);
  endtask

  task automatic t_idle;
    logic [31:0] held;
    issue(4'd0, 4'd8, 4'd8, 32'd100, 32'd23, 8'h0);
    held = result;
    @(negedge clk);
    opa = 32'h5555_5555;
    op = 4'd0;
    @(posedge clk);
    #1;
    chk("R1 idle wr_en", {31'h0, wr_en}, 32'h0);
    chk("R1 idle hold", result, held);
    chk("R1 idle index hold", {28'h0, wr_idx}, 32'd8);
  endtask

  initial begin
    #(8 * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; op = 4'd0; dst_idx = 4'd0; src_idx = 4'd0;
    opa = 32'h0; opb = 32'h0; imm = 8'h0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_logic();
    t_shift();
    t_load();
    t_compare();
    t_const();
    t_pair();
    t_misc();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule